// File: doc/BRIEF.md
# Event-Camera Address Preprocessor

This block conditions the address stream of a 128 by 128 event-based vision sensor before the events reach the compute layers. Each event carries a column, a row and a polarity bit and enters on a valid/ready handshake. The block applies a fixed chain of transforms to every event. It first selects events by polarity. It then mirrors each axis on request and rotates the image in quarter turns. It divides the coordinates down for pooling, and it discards any event whose pooled position falls outside a rectangular window. A surviving event is offered to two independent destinations, each with its own enable and its own handshake.

The settings sit in three registers that a simple write strobe loads. The data path has two registers: a geometry stage after the polarity, mirror and rotate logic, and an output stage after the pooling and window logic. The block accepts one event per cycle while neither destination stalls. Backpressure never drops an event.

Top module: `evt_prep_top`

## Requirements
- R1: After reset `in_ready` is 1 and both output valids are 0. The settings reset to pass both polarities, no mirroring, no rotation, 1:1 pooling, destination 0 on, destination 1 off, and a window of 0..127 on both axes.
- R2: The polarity mode sits in address 0 bits [1:0]. 0 passes only events with polarity 1, 1 passes only events with polarity 0, 2 passes both with their polarity kept, and 3 passes both with the output polarity forced to 0.
- R3: Address 0 bit 2 mirrors the column (x becomes 127-x) and bit 3 mirrors the row (y becomes 127-y). Mirroring is applied before rotation.
- R4: Address 0 bits [5:4] select rotation after mirroring. 0 leaves (x,y). 1 gives (127-y, x). 2 gives (127-x, 127-y). 3 gives (y, 127-x).
- R5: Address 0 bits [7:6] select pooling after rotation. 0 divides both coordinates by 1, 1 divides by 2, and 2 or 3 divide by 4, with the result rounded down.
- R6: Address 1 holds the column bounds (low in bits [6:0], high in bits [14:8]) and address 2 holds the row bounds in the same layout. An event passes only if its pooled column and pooled row each lie within their bounds, both bounds inclusive.
- R7: Address 0 bit 8 enables destination 0 and bit 9 enables destination 1. A passing event raises the valid of each enabled destination, and each valid clears on its own handshake. An event with no destination enabled vanishes without stalling the input.
- R8: `in_ready` is 0 exactly while some destination holds a valid event that its ready does not take in this cycle. A stalled output keeps its coordinates and polarity unchanged, and no event is lost.
- R9: An event accepted at clock edge k appears on the outputs after edge k+1. With both readies high, back-to-back events leave one per cycle in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 2 | Settings register address |
| cfg_wdata | input | 16 | Settings write data |
| in_valid | input | 1 | Input event valid |
| in_ready | output | 1 | Input event accepted when high with valid |
| in_x | input | 7 | Input column |
| in_y | input | 7 | Input row |
| in_pol | input | 1 | Input polarity |
| o0_valid | output | 1 | Destination 0 event valid |
| o0_ready | input | 1 | Destination 0 accepts |
| o1_valid | output | 1 | Destination 1 event valid |
| o1_ready | input | 1 | Destination 1 accepts |
| out_x | output | 7 | Output column, shared by both destinations |
| out_y | output | 7 | Output row, shared by both destinations |
| out_pol | output | 1 | Output polarity, shared by both destinations |

## Verification
The hardest case to reach from the ports is a split stall. Both destinations hold one event, one of them takes it and the other does not, and a further event waits in the geometry stage while yet another event is held at the input. The bench reaches this state by enabling both destinations and driving the two ready lines apart across several cycles. It then checks that the input stays blocked, that the remaining output holds its value, and that the queued events emerge in order once the ready rises. A second bench section sweeps every mix of polarity, mirror, rotation and pooling over corner and interior pixels, and then runs a full sweep of columns and rows across the window edges.

// File: rtl/evt_prep_pkg.sv
package evt_prep_pkg;

  typedef enum logic [1:0] {
    POL_ON    = 2'd0,
    POL_OFF   = 2'd1,
    POL_BOTH  = 2'd2,
    POL_MERGE = 2'd3
  } pol_mode_e;

  typedef struct packed {
    logic      d1_en;
    logic      d0_en;
    logic [1:0] pool;
    logic [1:0] rot;
    logic      mir_y;
    logic      mir_x;
    pol_mode_e pol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int HI_LSB = 8;

  localparam ctrl_t CTRL_RST = '{d1_en: 1'b0, d0_en: 1'b1, pool: 2'd0, rot: 2'd0,
                                 mir_y: 1'b0, mir_x: 1'b0, pol: POL_BOTH};

  function automatic logic pol_pass(input pol_mode_e m, input logic p);
    case (m)
      POL_ON:  return p;
      POL_OFF: return ~p;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic pol_out(input pol_mode_e m, input logic p);
    return (m == POL_MERGE) ? 1'b0 : p;
  endfunction

  function automatic logic [1:0] pool_shift(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/evt_prep_cfg.sv
module evt_prep_cfg
  import evt_prep_pkg::*;
#(
  parameter int COORD_W = 7,
  parameter int AW      = 2,
  parameter int DW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output ctrl_t              ctrl,
  output logic [COORD_W-1:0] x_lo,
  output logic [COORD_W-1:0] x_hi,
  output logic [COORD_W-1:0] y_lo,
  output logic [COORD_W-1:0] y_hi
);
  localparam logic [COORD_W-1:0] MAXC = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      x_lo <= '0;
      x_hi <= MAXC;
      y_lo <= '0;
      y_hi <= MAXC;
    end else if (we) begin
      case (addr)
        AW'(0): ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        AW'(1): begin
          x_lo <= wdata[COORD_W-1:0];
          x_hi <= wdata[HI_LSB +: COORD_W];
        end
        AW'(2): begin
          y_lo <= wdata[COORD_W-1:0];
          y_hi <= wdata[HI_LSB +: COORD_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_prep_geom.sv
module evt_prep_geom
  import evt_prep_pkg::*;
#(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               in_fire,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic               in_p,
  input  ctrl_t              ctrl,
  output logic               s1_vld,
  output logic [COORD_W-1:0] s1_x,
  output logic [COORD_W-1:0] s1_y,
  output logic               s1_p
);
  localparam logic [COORD_W-1:0] MAXC = '1;

  function automatic logic [COORD_W-1:0] flip(input logic [COORD_W-1:0] c);
    return MAXC - c;
  endfunction

  logic               pass;
  logic [COORD_W-1:0] mx, my, rx, ry;

  always_comb begin
    pass = pol_pass(ctrl.pol, in_p);
    mx   = ctrl.mir_x ? flip(in_x) : in_x;
    my   = ctrl.mir_y ? flip(in_y) : in_y;
    case (ctrl.rot)
      2'd1:    begin rx = flip(my); ry = mx;       end
      2'd2:    begin rx = flip(mx); ry = flip(my); end
      2'd3:    begin rx = my;       ry = flip(mx); end
      default: begin rx = mx;       ry = my;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_x   <= '0;
      s1_y   <= '0;
      s1_p   <= 1'b0;
    end else if (advance) begin
      s1_vld <= in_fire && pass;
      s1_x   <= rx;
      s1_y   <= ry;
      s1_p   <= pol_out(ctrl.pol, in_p);
    end
  end
endmodule

// File: rtl/evt_prep_pool_roi.sv
module evt_prep_pool_roi
  import evt_prep_pkg::*;
#(
  parameter int COORD_W = 7
) (
  input  logic [COORD_W-1:0] s1_x,
  input  logic [COORD_W-1:0] s1_y,
  input  logic [1:0]         pool,
  input  logic [COORD_W-1:0] x_lo,
  input  logic [COORD_W-1:0] x_hi,
  input  logic [COORD_W-1:0] y_lo,
  input  logic [COORD_W-1:0] y_hi,
  output logic [COORD_W-1:0] px,
  output logic [COORD_W-1:0] py,
  output logic               roi_hit
);
  logic [1:0] sh;

  always_comb begin
    sh      = pool_shift(pool);
    px      = s1_x >> sh;
    py      = s1_y >> sh;
    roi_hit = (px >= x_lo) && (px <= x_hi) && (py >= y_lo) && (py <= y_hi);
  end
endmodule

// File: rtl/evt_prep_fanout.sv
module evt_prep_fanout #(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               d0_en,
  input  logic               d1_en,
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic               pp,
  input  logic               o0_ready,
  input  logic               o1_ready,
  output logic               o0_valid,
  output logic               o1_valid,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic               out_pol,
  output logic               advance
);
  assign advance = !(o0_valid && !o0_ready) && !(o1_valid && !o1_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o0_valid <= 1'b0;
      o1_valid <= 1'b0;
      out_x    <= '0;
      out_y    <= '0;
      out_pol  <= 1'b0;
    end else if (load) begin
      o0_valid <= d0_en;
      o1_valid <= d1_en;
      out_x    <= px;
      out_y    <= py;
      out_pol  <= pp;
    end else begin
      if (o0_ready) o0_valid <= 1'b0;
      if (o1_ready) o1_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_prep_top.sv
module evt_prep_top
  import evt_prep_pkg::*;
#(
  parameter int COORD_W = 7,
  parameter int CFG_AW  = 2,
  parameter int CFG_DW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic               in_pol,
  output logic               o0_valid,
  input  logic               o0_ready,
  output logic               o1_valid,
  input  logic               o1_ready,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic               out_pol
);
  ctrl_t              ctrl;
  logic [COORD_W-1:0] x_lo, x_hi, y_lo, y_hi;
  logic               advance, in_fire, load_evt;
  logic               s1_vld, s1_p, roi_hit;
  logic [COORD_W-1:0] s1_x, s1_y, px, py;

  assign in_ready = advance;
  assign in_fire  = in_valid && advance;
  assign load_evt = advance && s1_vld && roi_hit;

  evt_prep_cfg #(.COORD_W(COORD_W), .AW(CFG_AW), .DW(CFG_DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi)
  );

  evt_prep_geom #(.COORD_W(COORD_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .advance(advance), .in_fire(in_fire),
    .in_x(in_x), .in_y(in_y), .in_p(in_pol), .ctrl(ctrl),
    .s1_vld(s1_vld), .s1_x(s1_x), .s1_y(s1_y), .s1_p(s1_p)
  );

  evt_prep_pool_roi #(.COORD_W(COORD_W)) u_pool (
    .s1_x(s1_x), .s1_y(s1_y), .pool(ctrl.pool),
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi),
    .px(px), .py(py), .roi_hit(roi_hit)
  );

  evt_prep_fanout #(.COORD_W(COORD_W)) u_fan (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .d0_en(ctrl.d0_en), .d1_en(ctrl.d1_en),
    .px(px), .py(py), .pp(s1_p), .o0_ready(o0_ready), .o1_ready(o1_ready),
    .o0_valid(o0_valid), .o1_valid(o1_valid), .out_x(out_x), .out_y(out_y),
    .out_pol(out_pol), .advance(advance)
  );
endmodule

// File: rtl/evt_prep_chk.sv
module evt_prep_chk #(
  parameter int COORD_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               o0_valid,
  input logic               o0_ready,
  input logic               o1_valid,
  input logic               o1_ready,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y,
  input logic               out_pol,
  input logic               s1_vld,
  input logic               load_evt
);
  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((o0_valid && !o0_ready) || (o1_valid && !o1_ready)) |-> !in_ready);

  // R8
  idle_opens_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!o0_valid && !o1_valid) |-> in_ready);

  // R8
  hold0_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o0_valid && !o0_ready) |=> (o0_valid && $stable(out_x) && $stable(out_y) && $stable(out_pol)));

  // R8
  hold1_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o1_valid && !o1_ready) |=> (o1_valid && $stable(out_x) && $stable(out_y) && $stable(out_pol)));

  // R7
  drain0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o0_valid && o0_ready && !load_evt) |=> !o0_valid);

  // R9
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o0_valid) |-> $past(s1_vld));
endmodule

bind evt_prep_top evt_prep_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .o0_valid(o0_valid), .o0_ready(o0_ready), .o1_valid(o1_valid), .o1_ready(o1_ready),
  .out_x(out_x), .out_y(out_y), .out_pol(out_pol),
  .s1_vld(s1_vld), .load_evt(load_evt)
);

// File: tb/evt_prep_top_tb.sv
`timescale 1ns/1ps
module evt_prep_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_x = '0, in_y = '0;
  logic        in_pol = 1'b0;
  logic        o0_valid, o1_valid;
  logic        o0_ready = 1'b1, o1_ready = 1'b1;
  logic [6:0]  out_x, out_y;
  logic        out_pol;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side copy of the settings
  int pm = 2, mx = 0, my = 0, rot = 0, pool = 0, d0 = 1, d1 = 0;
  int xlo = 0, xhi = 127, ylo = 0, yhi = 127;

  always #2.5 clk = ~clk;

  evt_prep_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_pol(in_pol),
    .o0_valid(o0_valid), .o0_ready(o0_ready), .o1_valid(o1_valid), .o1_ready(o1_ready),
    .out_x(out_x), .out_y(out_y), .out_pol(out_pol)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctrl();
    wr(0, pm | (mx << 2) | (my << 3) | (rot << 4) | (pool << 6) | (d0 << 8) | (d1 << 9));
  endtask

  task automatic set_win();
    wr(1, xlo | (xhi << 8));
    wr(2, ylo | (yhi << 8));
  endtask

  // reference transform: quarter turns applied one at a time, mirrors by xor
  task automatic model(input int x, input int y, input int p,
                       output bit v, output int ox, output int oy, output int op);
    int tx, ty, t, dv;
    bit pass;
    pass = (pm == 0) ? (p == 1) : (pm == 1) ? (p == 0) : 1'b1;
    op = (pm == 3) ? 0 : p;
    tx = mx ? (x ^ 127) : x;
    ty = my ? (y ^ 127) : y;
    for (int r = 0; r < rot; r++) begin
      t = tx; tx = 127 - ty; ty = t;
    end
    dv = (pool == 0) ? 1 : (pool == 1) ? 2 : 4;
    ox = tx / dv; oy = ty / dv;
    v = pass && ox >= xlo && ox <= xhi && oy >= ylo && oy <= yhi;
  endtask

  task automatic send_one(input string req, input int x, input int y, input int p);
    bit v; int ex, ey, ep;
    model(x, y, p, v, ex, ey, ep);
    @(negedge clk);
    in_valid = 1'b1; in_x = 7'(x); in_y = 7'(y); in_pol = 1'(p);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk({req, " dest0 valid"}, o0_valid == (v && d0 == 1), int'(o0_valid), int'(v && d0 == 1));
    chk({req, " dest1 valid"}, o1_valid == (v && d1 == 1), int'(o1_valid), int'(v && d1 == 1));
    if (v) begin
      chk({req, " x"}, int'(out_x) == ex, int'(out_x), ex);
      chk({req, " y"}, int'(out_y) == ey, int'(out_y), ey);
      chk({req, " pol"}, int'(out_pol) == ep, int'(out_pol), ep);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ev_x[6] = '{0, 127, 0, 127, 5, 64};
    int ev_y[6] = '{0, 0, 127, 127, 90, 33};
    int sx[4]   = '{3, 40, 77, 120};
    int sy[4]   = '{9, 100, 1, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and default settings
    chk("R1 in_ready", in_ready == 1'b1, int'(in_ready), 1);
    chk("R1 o0_valid", o0_valid == 1'b0, int'(o0_valid), 0);
    chk("R1 o1_valid", o1_valid == 1'b0, int'(o1_valid), 0);
    send_one("R1 defaults", 10, 20, 1);
    send_one("R1 defaults", 127, 0, 0);

    // R2 R3 R4 R5: sweep of polarity, mirror, rotation and pooling
    d0 = 1; d1 = 1;
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 4; r++)
          for (int q = 0; q < 4; q++) begin
            pm = a; mx = m & 1; my = m >> 1; rot = r; pool = q;
            set_ctrl();
            for (int e = 0; e < 6; e++)
              for (int p = 0; p < 2; p++)
                send_one("R2/R3/R4/R5 sweep", ev_x[e], ev_y[e], p);
          end

    // R6: window edges on pooled coordinates
    pm = 2; mx = 0; my = 0; rot = 0; pool = 1; d0 = 1; d1 = 0;
    set_ctrl();
    xlo = 10; xhi = 20; ylo = 30; yhi = 40;
    set_win();
    for (int x = 0; x < 128; x++) send_one("R6 column sweep", x, 70, 1);
    for (int y = 0; y < 128; y++) send_one("R6 row sweep", 30, y, 0);
    xlo = 0; xhi = 127; ylo = 0; yhi = 127;
    set_win();
    pool = 0;
    set_ctrl();

    // R7: no destination enabled drops silently, input stays open
    d0 = 0; d1 = 0;
    set_ctrl();
    send_one("R7 none enabled", 50, 60, 1);
    chk("R7 input open", in_ready == 1'b1, int'(in_ready), 1);
    d1 = 1;
    set_ctrl();
    send_one("R7 dest1 only", 50, 60, 1);

    // R9: back-to-back stream, one per cycle, in order
    d0 = 1; d1 = 1;
    set_ctrl();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R9 stream valid", o0_valid && o1_valid, int'(o0_valid), 1);
        chk("R9 stream x", int'(out_x) == sx[i-2], int'(out_x), sx[i-2]);
        chk("R9 stream y", int'(out_y) == sy[i-2], int'(out_y), sy[i-2]);
      end
      if (i < 4) begin
        in_valid = 1'b1; in_x = 7'(sx[i]); in_y = 7'(sy[i]); in_pol = 1'b1;
      end else in_valid = 1'b0;
    end
    @(negedge clk);

    // R8: split stall; dest0 takes, dest1 holds, queued events wait
    o1_ready = 1'b0;
    in_valid = 1'b1; in_x = 7'd11; in_y = 7'd12; in_pol = 1'b1;
    @(negedge clk);
    in_x = 7'd21; in_y = 7'd22;
    @(negedge clk);
    in_x = 7'd31; in_y = 7'd32;
    chk("R8 both hold A", o0_valid && o1_valid && out_x == 7'd11, int'(out_x), 11);
    chk("R8 input blocked", in_ready == 1'b0, int'(in_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 dest0 taken", o0_valid == 1'b0, int'(o0_valid), 0);
      chk("R8 dest1 holds", o1_valid && out_x == 7'd11 && out_y == 7'd12, int'(out_x), 11);
      chk("R8 input blocked", in_ready == 1'b0, int'(in_ready), 0);
    end
    o1_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 B after release", o0_valid && o1_valid && out_x == 7'd21, int'(out_x), 21);
    @(negedge clk);
    chk("R8 C follows", o0_valid && o1_valid && out_x == 7'd31 && out_y == 7'd32, int'(out_x), 31);
    @(negedge clk);
    chk("R8 drained", !o0_valid && !o1_valid && in_ready, int'(o0_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule